// File: doc/BRIEF.md
# Queued Memory-to-Memory DMA Command Engine

This engine takes transfer commands from a register write port and executes them one after another over a simple word-wide memory master. Software programs a source address, a destination address and two word counts. The write to the destination count register turns the four values into one command and places it in a small in-order queue. The engine takes the oldest command and reads its source in bounded chunks, one 32-bit word per granted memory cycle.

Two routing modes are chosen by the `loopback` input at the start of each chunk. In loopback mode each word that is read is written back to the destination address, and the destination pointer and count advance with it. Otherwise each word is offered on a valid/ready output stream, and the destination count is decremented so that the command can retire. When a command retires, two sticky done flags are raised and the command leaves the queue. The queue fill state and an overflow flag are reported on status outputs.

Top module: `dma_cmd_engine`

## Requirements
- R1: A write to offset 0x24 (destination word count) pushes one command built from the current contents of offsets 0x18 (source address), 0x1C (destination address) and 0x20 (source word count), together with the write data. Writes to any other offset never push.
- R2: The captured source and destination addresses have bits [1:0] cleared, so every memory access the engine issues is word aligned.
- R3: Only bits [26:0] of each word count are kept. The byte count of a command is the word count times 4.
- R4: The queue holds up to 10 commands and retires them in push order. `q_level` gives the number held, and `q_full`/`q_empty` follow it. After reset the queue is empty.
- R5: A push while the queue is full is dropped, the level is unchanged, and the sticky `sts_ovf` flag (status bit 14) is set.
- R6: A chunk moves at most 1024 bytes, no more than the source bytes remaining, and in loopback mode no more than the destination bytes remaining. One idle cycle with no memory request and no stream output separates chunks, and another such cycle retires the command.
- R7: In loopback mode each read word is written to the current destination address in the next granted cycle. Otherwise no memory write is issued, and each word is held on `st_data` with `st_valid` high until `st_ready`.
- R8: Retiring a command sets the sticky flags `sts_done` (status bit 13) and `sts_pdone` (status bit 12). Writing ones to offset 0x0C at bit positions 12, 13 and 14 clears the matching flags. A command with both counts zero retires without any memory access.
- R9: In loopback mode the command retires once the shorter of the two counts has been copied. Any source words left over are never read.
- R10: When loopback is off, the command retires once the source is exhausted. The destination count decreases by 4 per streamed word and stops at zero, whether it is larger or smaller than the source count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| loopback | input | 1 | Routing mode, sampled at each chunk start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid in the granted cycle |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_ready | input | 1 | Stream sink accepts the word |
| busy | output | 1 | A command is being executed |
| q_full | output | 1 | Queue holds 10 commands |
| q_empty | output | 1 | Queue holds no command |
| q_level | output | 4 | Number of queued commands |
| sts_done | output | 1 | Sticky command-done flag |
| sts_pdone | output | 1 | Sticky partial-done flag |
| sts_ovf | output | 1 | Sticky queue-overflow flag |

## Verification
Several properties are checked on every cycle: word alignment of memory addresses, writes only during loopback chunks, a stable stream word while it is stalled, the queue level bound and flag exclusivity, a dropped push setting the overflow flag without changing the level, and a retire setting both done flags. Other behaviour can only be shown by the bench's scenarios. These are the data moved and the order it arrives in, the in-order retirement of queued commands, the count of 1024-byte chunk boundaries, the truncation to the shorter count in loopback, the masking of the count registers, and the clearing of the status flags.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam int ADDR_W = 32;
  localparam int WCNT_W = 27;
  localparam int BCNT_W = WCNT_W + 2;

  typedef struct packed {
    logic [ADDR_W-1:0] src_a;
    logic [ADDR_W-1:0] dst_a;
    logic [BCNT_W-1:0] src_b;
    logic [BCNT_W-1:0] dst_b;
  } dma_cmd_t;

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  function automatic logic [BCNT_W-1:0] words_to_bytes(input logic [WCNT_W-1:0] w);
    return {w, 2'b00};
  endfunction

  // Bytes the next chunk may move: bounded by the cap, the source and,
  // when copying, the destination.
  function automatic logic [BCNT_W-1:0] chunk_len(input logic [BCNT_W-1:0] src_rem,
                                                  input logic [BCNT_W-1:0] dst_rem,
                                                  input logic              copy,
                                                  input logic [BCNT_W-1:0] cap);
    logic [BCNT_W-1:0] m;
    m = src_rem;
    if (copy && (dst_rem < m)) m = dst_rem;
    if (m > cap) m = cap;
    return m;
  endfunction

  function automatic logic [BCNT_W-1:0] dec_sat4(input logic [BCNT_W-1:0] v);
    return (v == '0) ? '0 : v - BCNT_W'(4);
  endfunction

endpackage

// File: rtl/dma_cmd_fifo.sv
module dma_cmd_fifo #(
  parameter int DEPTH = 10,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_p, rd_p;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign head  = slots[rd_p];

  always_ff @(posedge clk) begin
    if (push) slots[wr_p] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p  <= '0;
      rd_p  <= '0;
      level <= '0;
    end else begin
      if (push) wr_p <= nxt(wr_p);
      if (pop)  rd_p <= nxt(rd_p);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_eng_pkg::*;
#(
  parameter int CHUNK_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              have_cmd,
  input  dma_cmd_t          head,
  input  logic              loopback,
  output logic              retire,
  output logic              busy,
  output logic              lb_active,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              st_valid,
  output logic [31:0]       st_data,
  input  logic              st_ready
);

  localparam logic [BCNT_W-1:0] CAP = BCNT_W'(CHUNK_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_CHUNK, S_RD, S_WR, S_ST} mv_state_e;

  mv_state_e         state;
  logic [ADDR_W-1:0] src_a, dst_a;
  logic [BCNT_W-1:0] src_rem, dst_rem, left;
  logic [31:0]       data_q;
  logic              lb_c;
  logic [BCNT_W-1:0] next_chunk;

  assign next_chunk = chunk_len(src_rem, dst_rem, loopback, CAP);
  assign retire     = (state == S_CHUNK) && (next_chunk == '0);
  assign busy       = (state != S_IDLE);
  assign lb_active  = lb_c;

  always_comb begin
    mem_req   = (state == S_RD) || (state == S_WR);
    mem_we    = (state == S_WR);
    mem_addr  = (state == S_WR) ? dst_a : src_a;
    mem_wdata = data_q;
    st_valid  = (state == S_ST);
    st_data   = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      src_a   <= '0;
      dst_a   <= '0;
      src_rem <= '0;
      dst_rem <= '0;
      left    <= '0;
      data_q  <= '0;
      lb_c    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (have_cmd) begin
          src_a   <= head.src_a;
          dst_a   <= head.dst_a;
          src_rem <= head.src_b;
          dst_rem <= head.dst_b;
          state   <= S_CHUNK;
        end
        S_CHUNK: begin
          lb_c <= loopback;
          if (next_chunk == '0) begin
            state <= S_IDLE;
          end else begin
            left  <= next_chunk;
            state <= S_RD;
          end
        end
        S_RD: if (mem_gnt) begin
          data_q  <= mem_rdata;
          src_a   <= src_a + ADDR_W'(4);
          src_rem <= src_rem - BCNT_W'(4);
          left    <= left - BCNT_W'(4);
          state   <= lb_c ? S_WR : S_ST;
        end
        S_WR: if (mem_gnt) begin
          dst_a   <= dst_a + ADDR_W'(4);
          dst_rem <= dec_sat4(dst_rem);
          state   <= (left == '0) ? S_CHUNK : S_RD;
        end
        S_ST: if (st_ready) begin
          dst_rem <= dec_sat4(dst_rem);
          state   <= (left == '0) ? S_CHUNK : S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_cmd_engine.sv
module dma_cmd_engine
  import dma_eng_pkg::*;
#(
  parameter int QDEPTH      = 10,
  parameter int CHUNK_BYTES = 1024,
  localparam int LVL_W      = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              loopback,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              st_valid,
  output logic [31:0]       st_data,
  input  logic              st_ready,
  output logic              busy,
  output logic              q_full,
  output logic              q_empty,
  output logic [LVL_W-1:0]  q_level,
  output logic              sts_done,
  output logic              sts_pdone,
  output logic              sts_ovf
);

  localparam logic [7:0] OFS_STS  = 8'h0C;
  localparam logic [7:0] OFS_SRCA = 8'h18;
  localparam logic [7:0] OFS_DSTA = 8'h1C;
  localparam logic [7:0] OFS_SRCN = 8'h20;
  localparam logic [7:0] OFS_DSTN = 8'h24;
  localparam int BIT_PDONE = 12;
  localparam int BIT_DONE  = 13;
  localparam int BIT_OVF   = 14;

  logic [ADDR_W-1:0] src_addr_q, dst_addr_q;
  logic [WCNT_W-1:0] src_cnt_q;
  dma_cmd_t          new_cmd, head_cmd;
  logic              push_req, push_ok, ovf_evt, retire, lb_active, sts_wr;

  assign push_req = reg_we && (reg_addr == OFS_DSTN);
  assign push_ok  = push_req && !q_full;
  assign ovf_evt  = push_req && q_full;
  assign sts_wr   = reg_we && (reg_addr == OFS_STS);

  always_comb begin
    new_cmd.src_a = word_align(src_addr_q);
    new_cmd.dst_a = word_align(dst_addr_q);
    new_cmd.src_b = words_to_bytes(src_cnt_q);
    new_cmd.dst_b = words_to_bytes(reg_wdata[WCNT_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr_q <= '0;
      dst_addr_q <= '0;
      src_cnt_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFS_SRCA) src_addr_q <= reg_wdata;
      if (reg_addr == OFS_DSTA) dst_addr_q <= reg_wdata;
      if (reg_addr == OFS_SRCN) src_cnt_q  <= reg_wdata[WCNT_W-1:0];
    end
  end

  // Sticky flags: a new event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_done  <= 1'b0;
      sts_pdone <= 1'b0;
      sts_ovf   <= 1'b0;
    end else begin
      sts_done  <= retire  || (sts_done  && !(sts_wr && reg_wdata[BIT_DONE]));
      sts_pdone <= retire  || (sts_pdone && !(sts_wr && reg_wdata[BIT_PDONE]));
      sts_ovf   <= ovf_evt || (sts_ovf   && !(sts_wr && reg_wdata[BIT_OVF]));
    end
  end

  dma_cmd_fifo #(.DEPTH(QDEPTH), .W($bits(dma_cmd_t))) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .din   (new_cmd),
    .pop   (retire),
    .head  (head_cmd),
    .full  (q_full),
    .empty (q_empty),
    .level (q_level)
  );

  dma_mover #(.CHUNK_BYTES(CHUNK_BYTES)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .have_cmd  (!q_empty),
    .head      (head_cmd),
    .loopback  (loopback),
    .retire    (retire),
    .busy      (busy),
    .lb_active (lb_active),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .st_valid  (st_valid),
    .st_data   (st_data),
    .st_ready  (st_ready)
  );

endmodule

// File: rtl/dma_engine_checker.sv
module dma_engine_checker #(
  parameter int QDEPTH = 10,
  parameter int LVL_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic             st_valid,
  input logic [31:0]      st_data,
  input logic             st_ready,
  input logic             q_full,
  input logic             q_empty,
  input logic [LVL_W-1:0] q_level,
  input logic             sts_done,
  input logic             sts_pdone,
  input logic             sts_ovf,
  input logic             retire,
  input logic             ovf_evt,
  input logic             lb_active
);

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= LVL_W'(QDEPTH));

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> sts_ovf);

  assert_ovf_level_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !retire) |=> (q_level == $past(q_level)));

  assert_write_in_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> lb_active);

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_valid && mem_req));

  assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (sts_done && sts_pdone));

endmodule

bind dma_cmd_engine dma_engine_checker #(.QDEPTH(QDEPTH), .LVL_W(LVL_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .st_valid  (st_valid),
  .st_data   (st_data),
  .st_ready  (st_ready),
  .q_full    (q_full),
  .q_empty   (q_empty),
  .q_level   (q_level),
  .sts_done  (sts_done),
  .sts_pdone (sts_pdone),
  .sts_ovf   (sts_ovf),
  .retire    (retire),
  .ovf_evt   (ovf_evt),
  .lb_active (lb_active)
);

// File: tb/tb_dma_cmd_engine.sv
`timescale 1ns/1ps
module tb_dma_cmd_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        loopback = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_gnt;
  logic        st_valid, st_ready;
  logic [31:0] st_data;
  logic        busy, q_full, q_empty, sts_done, sts_pdone, sts_ovf;
  logic [3:0]  q_level;

  logic        gnt_en = 1'b1;
  logic        rdy_toggle = 1'b0;
  int          cyc = 0;
  int          errors = 0, checks = 0;
  int          rd_cnt = 0, wr_cnt = 0, cap_n = 0, gap_cnt = 0;
  logic [31:0] mem [4096];
  logic [31:0] cap [512];

  always #2.5 clk = ~clk;

  assign mem_gnt   = gnt_en;
  assign st_ready  = rdy_toggle ? cyc[0] : 1'b1;
  assign mem_rdata = mem[mem_addr[13:2]];

  dma_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .loopback(loopback), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .st_valid(st_valid),
    .st_data(st_data), .st_ready(st_ready), .busy(busy), .q_full(q_full),
    .q_empty(q_empty), .q_level(q_level), .sts_done(sts_done),
    .sts_pdone(sts_pdone), .sts_ovf(sts_ovf)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 ^ (i * 32'h0001_0101);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_req && mem_gnt && !mem_we) rd_cnt++;
      if (mem_req && mem_gnt && mem_we) begin
        mem[mem_addr[13:2]] = mem_wdata;
        wr_cnt++;
      end
      if (st_valid && st_ready) begin
        if (cap_n < 512) cap[cap_n] = st_data;
        cap_n++;
      end
      if (busy && !mem_req && !st_valid) gap_cnt++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push_cmd(input logic [31:0] sa, input logic [31:0] da,
                          input logic [31:0] sn, input logic [31:0] dn);
    wr_reg(8'h18, sa);
    wr_reg(8'h1C, da);
    wr_reg(8'h20, sn);
    wr_reg(8'h24, dn);
  endtask

  task automatic clr_counts();
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; cap_n = 0; gap_cnt = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (q_empty && !busy) break;
    end
    @(negedge clk);
  endtask

  task automatic clr_sts();
    wr_reg(8'h0C, 32'h0000_7000);
  endtask

  task automatic t_reset();
    chk(q_empty == 1'b1, "R4 empty after reset", q_empty, 1);
    chk(q_full == 1'b0 && q_level == 0, "R4 level after reset", q_level, 0);
    chk(!busy && !mem_req && !st_valid, "R4 idle after reset", busy, 0);
    chk({sts_done, sts_pdone, sts_ovf} == 3'b000, "R8 flags after reset",
        {sts_done, sts_pdone, sts_ovf}, 0);
  endtask

  task automatic t_no_push();
    wr_reg(8'h18, 32'h100);
    wr_reg(8'h1C, 32'h200);
    wr_reg(8'h20, 32'h4);
    repeat (3) @(negedge clk);
    chk(q_level == 0 && !busy, "R1 other offsets do not push", q_level, 0);
  endtask

  task automatic t_stream();
    clr_counts();
    loopback = 1'b0; rdy_toggle = 1'b1;
    push_cmd(32'h103, 32'h3001, 8, 8);
    wait_idle();
    rdy_toggle = 1'b0;
    chk(cap_n == 8, "R7 stream word count", cap_n, 8);
    for (int k = 0; k < 8; k++)
      chk(cap[k] == pat(32'h40 + k), "R2 R7 stream data aligned source", cap[k], pat(32'h40 + k));
    chk(wr_cnt == 0, "R7 no writes without loopback", wr_cnt, 0);
    chk(sts_done && sts_pdone, "R8 done flags set", {sts_done, sts_pdone}, 2'b11);
    clr_sts();
    chk(!sts_done && !sts_pdone && !sts_ovf, "R8 flags cleared", {sts_done, sts_pdone}, 0);
  endtask

  task automatic t_loop();
    clr_counts();
    loopback = 1'b1;
    push_cmd(32'h200, 32'h802, 6, 6);
    wait_idle();
    chk(wr_cnt == 6, "R7 loopback write count", wr_cnt, 6);
    for (int k = 0; k < 6; k++)
      chk(mem[32'h200 + k] == pat(32'h80 + k), "R2 R7 loopback copy", mem[32'h200 + k], pat(32'h80 + k));
    chk(mem[32'h206] == pat(32'h206), "R7 loopback stops at count", mem[32'h206], pat(32'h206));
    clr_sts();
  endtask

  task automatic t_loop_short();
    clr_counts();
    loopback = 1'b1;
    push_cmd(32'h300, 32'hA00, 10, 4);
    wait_idle();
    chk(rd_cnt == 4, "R9 reads limited by destination", rd_cnt, 4);
    chk(wr_cnt == 4, "R9 writes limited by destination", wr_cnt, 4);
    chk(mem[32'h284] == pat(32'h284), "R9 no write past destination", mem[32'h284], pat(32'h284));
    chk(sts_done && q_empty, "R9 short command retires", sts_done, 1);
    clr_sts();
    loopback = 1'b0;
  endtask

  task automatic t_nonloop_counts();
    clr_counts();
    push_cmd(32'h400, 32'h0, 3, 9);
    wait_idle();
    chk(cap_n == 3 && sts_done, "R10 larger destination retires", cap_n, 3);
    clr_sts();
    clr_counts();
    push_cmd(32'h400, 32'h0, 5, 2);
    wait_idle();
    chk(cap_n == 5 && sts_done, "R10 smaller destination retires", cap_n, 5);
    clr_sts();
  endtask

  task automatic t_len_mask();
    clr_counts();
    push_cmd(32'h500, 32'h0, 32'hF800_0003, 32'hF800_0003);
    wait_idle();
    chk(cap_n == 3, "R3 count upper bits ignored", cap_n, 3);
    chk(cap[2] == pat(32'h142), "R3 bytes equal words times 4", cap[2], pat(32'h142));
    clr_sts();
  endtask

  task automatic t_order();
    clr_counts();
    gnt_en = 1'b0;
    push_cmd(32'h040, 32'h0, 2, 2);
    push_cmd(32'h080, 32'h0, 2, 2);
    push_cmd(32'h0C0, 32'h0, 2, 2);
    chk(q_level == 3 && !q_empty, "R4 level counts pushes", q_level, 3);
    gnt_en = 1'b1;
    wait_idle();
    chk(cap_n == 6, "R4 all queued words streamed", cap_n, 6);
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 2; k++)
        chk(cap[c*2+k] == pat(32'h10*(c+1) + k), "R4 in-order retirement",
            cap[c*2+k], pat(32'h10*(c+1) + k));
    clr_sts();
  endtask

  task automatic t_overflow();
    clr_counts();
    gnt_en = 1'b0;
    for (int k = 0; k < 10; k++) push_cmd(32'h140 + 4*k, 32'h0, 1, 1);
    chk(q_full && q_level == 10, "R4 full at ten", q_level, 10);
    chk(!sts_ovf, "R5 no overflow before eleventh", sts_ovf, 0);
    push_cmd(32'h1C0, 32'h0, 1, 1);
    chk(sts_ovf, "R5 overflow flag set", sts_ovf, 1);
    chk(q_level == 10, "R5 level kept on drop", q_level, 10);
    gnt_en = 1'b1;
    wait_idle();
    chk(cap_n == 10, "R5 dropped command never runs", cap_n, 10);
    chk(cap[9] == pat(32'h59), "R5 last executed command", cap[9], pat(32'h59));
    clr_sts();
    chk(!sts_ovf, "R5 overflow flag cleared", sts_ovf, 0);
  endtask

  task automatic t_chunks();
    clr_counts();
    push_cmd(32'h1000, 32'h0, 300, 300);
    wait_idle();
    chk(cap_n == 300, "R6 long command streamed", cap_n, 300);
    chk(cap[299] == pat(32'h400 + 299), "R6 last long word", cap[299], pat(32'h400 + 299));
    chk(gap_cnt == 3, "R6 two chunks plus retire", gap_cnt, 3);
    clr_sts();
    clr_counts();
    push_cmd(32'h1000, 32'h0, 256, 256);
    wait_idle();
    chk(gap_cnt == 2, "R6 one full chunk plus retire", gap_cnt, 2);
    clr_sts();
  endtask

  task automatic t_empty_cmd();
    clr_counts();
    push_cmd(32'h0, 32'h0, 0, 0);
    wait_idle();
    chk(sts_done && sts_pdone, "R8 zero command retires", sts_done, 1);
    chk(rd_cnt == 0 && cap_n == 0, "R8 zero command no access", rd_cnt, 0);
    clr_sts();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_push();
    t_stream();
    t_loop();
    t_loop_short();
    t_nonloop_counts();
    t_len_mask();
    t_order();
    t_overflow();
    t_chunks();
    t_empty_cmd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule